// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the interrupt mask and the latched interrupt status of a serial port and drives a single level-sensitive interrupt line. It observes five live conditions from the receive and transmit paths: receive trigger level reached, receive empty, receive full, transmit empty and transmit full. It also takes five single-cycle event pulses: receive overrun, framing error, parity error, receive timeout and modem status change. Each live condition or event latches into its own bit of a status word. That bit stays set until software clears it.

Software reaches the block through a plain register port: a write strobe with a byte address and a data word, and a separate read address with a combinational read data word. The mask cannot be written directly. Bits are turned on through a set-only enable register and turned off through a clear-only disable register. The status word clears when a one is written to a bit. The interrupt line is high whenever at least one latched status bit is also enabled in the mask.

Top module: `uirq_unit`

## Requirements
- R1: Live input bit i (0 = receive trigger reached, 1 = receive empty, 2 = receive full, 3 = transmit empty, 4 = transmit full) sets status bit i at the next clock edge. The bit stays set after the live input falls.
- R2: Event pulse bit j (0 = overrun, 1 = framing, 2 = parity, 3 = timeout, 4 = modem change) sets status bit j+5 at the next clock edge. The bit stays set afterwards.
- R3: A write to byte offset 0x08 ORs data bits 9:0 into the mask. Data bits 31:10 are ignored.
- R4: A write to byte offset 0x0C clears every mask bit whose data bit is one. Mask bits written as zero are left as they were.
- R5: A write to byte offset 0x10 leaves the mask unchanged. A read of 0x10 returns the mask in bits 9:0.
- R6: A write to byte offset 0x14 clears every status bit written as one and leaves the others. A read of 0x14 returns the status in bits 9:0.
- R7: When a clear write and a set condition reach the same status bit at the same clock edge, the bit ends up set.
- R8: The irq output is high exactly when the bitwise AND of mask and status is nonzero. It follows register updates with no further delay.
- R9: While reset is active, the mask and status are zero and irq is low. The reset is applied asynchronously and released on the second clock edge after rst_n rises.
- R10: Reads of offsets 0x08, 0x0C and any unmapped offset return zero. Read bits 31:10 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_stat | input | 5 | Live receive/transmit conditions, bits 0 to 4 |
| evt_pulse | input | 5 | Single-cycle error and event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that event pulses and live conditions are sampled only at clock edges and that at most one register write arrives per cycle. Because of that, one clear and one set can meet only through the status offset. They also assume that no input is inspected while the internal synchronized reset is still active. The stimulus changes every input on the falling clock edge, issues a single write per step, returns live inputs and pulses to zero right after each sampled edge, and waits three edges after reset release before the next write.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned LIVE_W_DEF = 5;
  localparam int unsigned EVT_W_DEF  = 5;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 32;

  localparam logic [11:0] OFF_ENABLE  = 12'h008;
  localparam logic [11:0] OFF_DISABLE = 12'h00C;
  localparam logic [11:0] OFF_MASK    = 12'h010;
  localparam logic [11:0] OFF_STATUS  = 12'h014;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_SET_MASK,
    REG_CLR_MASK,
    REG_CLR_STAT
  } wr_kind_e;
endpackage

// File: rtl/uirq_rst_sync.sv
module uirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/uirq_regport.sv
module uirq_regport
  import uirq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned IRQ_W  = LIVE_W_DEF + EVT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [IRQ_W-1:0]  mask_q,
  input  logic [IRQ_W-1:0]  stat_q,
  output logic              mask_set_en,
  output logic              mask_clr_en,
  output logic              stat_clr_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - IRQ_W;
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DISABLE);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);

  wr_kind_e wr_kind;

  always_comb begin
    wr_kind = REG_NONE;
    if (wr_en) begin
      unique case (wr_addr)
        A_EN:    wr_kind = REG_SET_MASK;
        A_DIS:   wr_kind = REG_CLR_MASK;
        A_STAT:  wr_kind = REG_CLR_STAT;
        default: wr_kind = REG_NONE;
      endcase
    end
  end

  assign mask_set_en = (wr_kind == REG_SET_MASK);
  assign mask_clr_en = (wr_kind == REG_CLR_MASK);
  assign stat_clr_en = (wr_kind == REG_CLR_STAT);

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_MASK:  rd_data = {{PAD_W{1'b0}}, mask_q};
      A_STAT:  rd_data = {{PAD_W{1'b0}}, stat_q};
      default: rd_data = '0;
    endcase
  end

  AST_WRITE_TO_MASK_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_addr == A_MASK) |-> !(mask_set_en || mask_clr_en || stat_clr_en)); // R5
  AST_ENDIS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_addr == A_EN || rd_addr == A_DIS) |-> (rd_data == '0)); // R10
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_data[DATA_W-1:IRQ_W] == '0)); // R10
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask
  import uirq_pkg::*;
#(
  parameter int unsigned IRQ_W = LIVE_W_DEF + EVT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] mask_q
);
  logic [IRQ_W-1:0] mask_d;
  logic             mask_ce;

  assign mask_ce = set_en | clr_en;

  always_comb begin
    mask_d = mask_q;
    if (set_en) begin
      mask_d = mask_q | wdata;
    end else if (clr_en) begin
      mask_d = mask_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  AST_ENABLE_ORS_IN: assert property (@(posedge clk) disable iff (!rst_ni)
    set_en |=> ((mask_q & $past(wdata)) == $past(wdata)) && ((mask_q & $past(mask_q)) == $past(mask_q))); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_en |=> ((mask_q & $past(wdata)) == '0) && (mask_q == ($past(mask_q) & ~$past(wdata)))); // R4
  AST_MASK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(set_en || clr_en) |=> $stable(mask_q)); // R5
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky
  import uirq_pkg::*;
#(
  parameter int unsigned LIVE_W = LIVE_W_DEF,
  parameter int unsigned EVT_W  = EVT_W_DEF,
  parameter int unsigned IRQ_W  = LIVE_W + EVT_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [LIVE_W-1:0] live_stat,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              clr_en,
  input  logic [IRQ_W-1:0]  clr_data,
  output logic [IRQ_W-1:0]  stat_q
);
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;
  logic [IRQ_W-1:0] stat_d;
  logic [IRQ_W-1:0] bit_ce;

  for (genvar gi = 0; gi < IRQ_W; gi++) begin : g_bit
    if (gi < LIVE_W) begin : g_live
      assign set_vec[gi] = live_stat[gi];
    end else begin : g_evt
      assign set_vec[gi] = evt_pulse[gi-LIVE_W];
    end

    assign clr_vec[gi] = clr_en & clr_data[gi];
    assign bit_ce[gi]  = set_vec[gi] | clr_vec[gi];

    always_comb begin
      stat_d[gi] = stat_q[gi];
      if (set_vec[gi]) begin
        stat_d[gi] = 1'b1;
      end else if (clr_vec[gi]) begin
        stat_d[gi] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q[gi] <= 1'b0;
      end else if (bit_ce[gi]) begin
        stat_q[gi] <= stat_d[gi];
      end
    end
  end

  AST_LIVE_LATCHES: assert property (@(posedge clk) disable iff (!rst_ni)
    (live_stat != '0) |=> ((stat_q[LIVE_W-1:0] & $past(live_stat)) == $past(live_stat))); // R1
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_pulse != '0) |=> ((stat_q[IRQ_W-1:LIVE_W] & $past(evt_pulse)) == $past(evt_pulse))); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clr_en && live_stat == '0 && evt_pulse == '0) |=> $stable(stat_q)); // R1
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && live_stat == '0 && evt_pulse == '0) |=> (stat_q == ($past(stat_q) & ~$past(clr_data)))); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_en && (clr_data & {evt_pulse, live_stat}) != '0)
      |=> ((stat_q & $past(clr_data & {evt_pulse, live_stat})) == $past(clr_data & {evt_pulse, live_stat}))); // R7
endmodule

// File: rtl/uirq_unit.sv
module uirq_unit
  import uirq_pkg::*;
#(
  parameter int unsigned LIVE_W = LIVE_W_DEF,
  parameter int unsigned EVT_W  = EVT_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_W-1:0] live_stat,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned IRQ_W = LIVE_W + EVT_W;

  logic             rst_int_n;
  logic             mask_set_en;
  logic             mask_clr_en;
  logic             stat_clr_en;
  logic [IRQ_W-1:0] mask_q;
  logic [IRQ_W-1:0] stat_q;
  logic [IRQ_W-1:0] wdata_lo;

  assign wdata_lo = wr_data[IRQ_W-1:0];

  uirq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  uirq_regport #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IRQ_W  (IRQ_W)
  ) u_regport (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .mask_q      (mask_q),
    .stat_q      (stat_q),
    .mask_set_en (mask_set_en),
    .mask_clr_en (mask_clr_en),
    .stat_clr_en (stat_clr_en),
    .rd_data     (rd_data)
  );

  uirq_mask #(
    .IRQ_W (IRQ_W)
  ) u_mask (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .set_en (mask_set_en),
    .clr_en (mask_clr_en),
    .wdata  (wdata_lo),
    .mask_q (mask_q)
  );

  uirq_sticky #(
    .LIVE_W (LIVE_W),
    .EVT_W  (EVT_W),
    .IRQ_W  (IRQ_W)
  ) u_sticky (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .live_stat (live_stat),
    .evt_pulse (evt_pulse),
    .clr_en    (stat_clr_en),
    .clr_data  (wdata_lo),
    .stat_q    (stat_q)
  );

  assign irq = |(mask_q & stat_q);

  AST_IRQ_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq) |-> (((stat_q & ~$past(stat_q)) | (mask_q & ~$past(mask_q))) != '0)); // R8
  AST_IRQ_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq) |-> (((~stat_q & $past(stat_q)) | (~mask_q & $past(mask_q))) != '0)); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_int_n |-> (mask_q == '0 && stat_q == '0 && !irq)); // R9
endmodule

// File: tb/uirq_unit_bench.sv
module uirq_unit_bench;
  localparam int unsigned LW = 5;
  localparam int unsigned EW = 5;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned NV = 15;

  logic          clk;
  logic          rst_n;
  logic [LW-1:0] live_stat;
  logic [EW-1:0] evt_pulse;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [LW-1:0] live;
    logic [EW-1:0] evt;
    logic [9:0]    exp_mask;
    logic [9:0]    exp_stat;
    logic          exp_irq;
  } vec_t;

  // Expected mask/status/irq after each step, derived from R1..R8.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,        5'h01, 5'h00, 10'h000, 10'h001, 1'b0}, // R1 live bit0
    '{1'b0, 8'h00, 32'h0,        5'h00, 5'h00, 10'h000, 10'h001, 1'b0}, // R1 sticks
    '{1'b0, 8'h00, 32'h0,        5'h00, 5'h01, 10'h000, 10'h021, 1'b0}, // R2 overrun -> bit5
    '{1'b0, 8'h00, 32'h0,        5'h00, 5'h10, 10'h000, 10'h221, 1'b0}, // R2 modem -> bit9
    '{1'b1, 8'h08, 32'h020,      5'h00, 5'h00, 10'h020, 10'h221, 1'b1}, // R3 R8
    '{1'b1, 8'h08, 32'h001,      5'h00, 5'h00, 10'h021, 10'h221, 1'b1}, // R3 OR
    '{1'b1, 8'h14, 32'h020,      5'h00, 5'h00, 10'h021, 10'h201, 1'b1}, // R6
    '{1'b1, 8'h14, 32'h001,      5'h00, 5'h00, 10'h021, 10'h200, 1'b0}, // R6 R8
    '{1'b1, 8'h0C, 32'h001,      5'h00, 5'h00, 10'h020, 10'h200, 1'b0}, // R4
    '{1'b1, 8'h10, 32'h3FF,      5'h00, 5'h00, 10'h020, 10'h200, 1'b0}, // R5
    '{1'b1, 8'h14, 32'h3FF,      5'h04, 5'h00, 10'h020, 10'h004, 1'b0}, // R7
    '{1'b1, 8'h08, 32'hFFFFFC00, 5'h00, 5'h00, 10'h020, 10'h004, 1'b0}, // R3 upper ignored
    '{1'b0, 8'h00, 32'h0,        5'h18, 5'h06, 10'h020, 10'h0DC, 1'b0}, // R1 R2
    '{1'b1, 8'h08, 32'h080,      5'h00, 5'h00, 10'h0A0, 10'h0DC, 1'b1}, // R3 R8
    '{1'b1, 8'h0C, 32'h3FF,      5'h00, 5'h00, 10'h000, 10'h0DC, 1'b0}  // R4 R8
  };

  uirq_unit u_uirq_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_stat (live_stat),
    .evt_pulse (evt_pulse),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; live_stat = '0; evt_pulse = '0;
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [DW-1:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  // drive at negedge, one edge, idle right after it, then sample
  task automatic step(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LW-1:0] l, input logic [EW-1:0] e);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; live_stat = l; evt_pulse = e;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic check_state(input string req, input logic [9:0] m, input logic [9:0] s, input logic i);
    logic [DW-1:0] v;
    read_reg(8'h10, v); chk({req, " mask"}, v, {22'd0, m});
    read_reg(8'h14, v); chk({req, " status"}, v, {22'd0, s});
    chk({req, " irq"}, {31'd0, irq}, {31'd0, i});
  endtask

  initial begin
    logic [DW-1:0] v;
    rst_n = 1'b0;
    rd_addr = '0;
    idle_inputs();
    repeat (4) @(posedge clk);
    #1;
    check_state("R9 reset", 10'h000, 10'h000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].wr, VECS[k].addr, VECS[k].data, VECS[k].live, VECS[k].evt);
      check_state($sformatf("vec%0d", k), VECS[k].exp_mask, VECS[k].exp_stat, VECS[k].exp_irq);
    end

    // R10: enable/disable offsets and unmapped offsets read zero
    step(1'b1, 8'h08, 32'h3FF, 5'h00, 5'h00);
    read_reg(8'h08, v); chk("R10 enable read", v, 32'h0);
    read_reg(8'h0C, v); chk("R10 disable read", v, 32'h0);
    read_reg(8'h3C, v); chk("R10 unmapped read", v, 32'h0);
    check_state("R8 all enabled", 10'h3FF, 10'h0DC, 1'b1);

    // R7 with an event pulse: timeout (bit8) set while clearing everything
    step(1'b1, 8'h14, 32'h3FF, 5'h00, 5'h08);
    check_state("R7 event wins", 10'h3FF, 10'h100, 1'b1);

    // R6: zero-written bits kept
    step(1'b1, 8'h14, 32'h000, 5'h00, 5'h00);
    check_state("R6 zero write", 10'h3FF, 10'h100, 1'b1);

    // R9: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #0.5;
    check_state("R9 async reset", 10'h000, 10'h000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    check_state("R9 after release", 10'h000, 10'h000, 1'b0);

    // R1: transmit full live bit after reset
    step(1'b0, 8'h00, 32'h0, 5'h10, 5'h00);
    check_state("R1 tx full", 10'h000, 10'h010, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule